// File: doc/BRIEF.md
# Local Address Window and Chip-Select Decoder

This block sits between a host-side bus target and a local bus. It holds a table of address windows, each made of three configuration words: a bus-side window base, a size mask whose low bit gives the space type, and a local base whose low bit enables the window. Every cycle it compares the incoming bus address and access type with all windows. The lowest-numbered matching window wins. The address is then remapped into local space: the offset inside the window is kept, and the masked upper bits are replaced by the local base.

The translated local address is also compared with a set of chip-select words. Each chip-select word packs an enable, a window position and a power-of-two window size into a single value. The window result, the winning index, the local address and the chip-select vector are registered, so they appear one clock after the access is presented. Software loads all configuration words through a single write port with a selector field.

Top module: `addr_window_decoder`

## Requirements
- R1: During and right after reset, every configuration word is zero, and `hit`, `hit_space`, `local_addr` and `chip_sel` are all zero.
- R2: Bit 0 of a window's size-mask word gives its type: 1 means the window answers I/O accesses (`bus_is_io`=1), 0 means it answers memory accesses. An access of the other type never hits that window.
- R3: Bit 0 of a window's local-base word enables the window. While that bit is 0, the window never hits.
- R4: An enabled window of the matching type hits when `bus_addr` AND M equals window-base AND M. Here M is the size-mask word with bit 0 cleared. A 1 KB window therefore uses the mask 0xFFFFFC00.
- R5: On a hit, `local_addr` = (`bus_addr` AND NOT M) OR (local-base AND M). For example, 0xFFCF0014 in a window at 0xFFCF0000 with mask 0xFFFFFC00 and local base 0x1001 gives 0x00001014.
- R6: When several windows hit, the lowest-numbered one wins, and its index is given on `hit_space`.
- R7: Outputs are registered. The result for the access presented in one cycle appears after the next rising clock edge. With `bus_valid`=0, all outputs are zero in the following cycle. On a miss, `hit_space` and `local_addr` are zero.
- R8: A write with `cfg_wr_en`=1 stores `cfg_wr_data` at the clock edge, so it first affects an access that is presented after that edge. Selector bits [4:3] choose the word kind: 0 = size mask, 1 = window base, 2 = local base, 3 = chip-select word. Bits [2:0] give the window or chip-select index.
- R9: A chip-select word with bit 0 set and its lowest set bit above bit 0 at position k describes a window of 2^(k+1) bytes. The window base is the word with bits k..0 cleared. For example, 0x1201 decodes to 0x1000–0x13FF and 0x311 decodes to 0x300–0x31F. Output `chip_sel[c]` is 1 when a window hit and the local address falls in chip-select window c. Several chip selects may be active together.
- R10: A chip-select word with no set bit above bit 0, or with bit 0 clear, never asserts. No chip select is asserted without a window hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 5 | Word kind [4:3] and index [2:0] |
| cfg_wr_data | input | 32 | Configuration word to store |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| bus_addr | input | 32 | Bus-side address |
| hit | output | 1 | Registered: a window matched |
| hit_space | output | 3 | Registered index of the winning window |
| local_addr | output | 32 | Registered translated local address |
| chip_sel | output | 4 | Registered chip-select vector |

## Verification
The assertions assume that software keeps each window base a multiple of its window size. When this holds, the kept offset and the substituted local bits never overlap. The assertions also assume that configuration changes take effect only at a clock edge, which allows them to compare a registered result with the configuration sampled one cycle earlier. The stimulus uses only aligned bases, such as an I/O window lowered to 0xFC00 with a 32-byte mask. Its random phase changes only local-base and chip-select words, so the window bases never drift off their size alignment.

// File: rtl/aw_pkg.sv
package aw_pkg;

    parameter int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        KIND_MASK  = 2'd0,
        KIND_WIN   = 2'd1,
        KIND_LBASE = 2'd2,
        KIND_CSEL  = 2'd3
    } reg_kind_e;

    // Low-bit mask of a chip-select window: the lowest set bit above bit 0
    // marks half the window size, so the mask covers that bit and all below.
    function automatic addr_t cs_low_mask(input addr_t word);
        addr_t sized;
        addr_t lowest;
        sized  = word & ~addr_t'(1);
        lowest = sized & (~sized + addr_t'(1));
        return lowest | (lowest - addr_t'(1));
    endfunction

    function automatic logic cs_has_size(input addr_t word);
        return |word[ADDR_W-1:1];
    endfunction

endpackage

// File: rtl/aw_cfg_regs.sv
module aw_cfg_regs
    import aw_pkg::*;
#(
    parameter int unsigned NUM_SPACES = 5,
    parameter int unsigned NUM_CS     = 4,
    parameter int unsigned IDX_W      = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  reg_kind_e                             wr_kind,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  addr_t                                 wr_data,
    output logic [NUM_SPACES-1:0][ADDR_W-1:0]     mask_o,
    output logic [NUM_SPACES-1:0][ADDR_W-1:0]     win_o,
    output logic [NUM_SPACES-1:0][ADDR_W-1:0]     lbase_o,
    output logic [NUM_CS-1:0][ADDR_W-1:0]         csel_o
);

    typedef struct packed {
        logic [NUM_SPACES-1:0][ADDR_W-1:0] mask;
        logic [NUM_SPACES-1:0][ADDR_W-1:0] win;
        logic [NUM_SPACES-1:0][ADDR_W-1:0] lbase;
        logic [NUM_CS-1:0][ADDR_W-1:0]     csel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_SPACES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    case (wr_kind)
                        KIND_MASK:  cfg_d.mask[i]  = wr_data;
                        KIND_WIN:   cfg_d.win[i]   = wr_data;
                        KIND_LBASE: cfg_d.lbase[i] = wr_data;
                        default: ;
                    endcase
                end
            end
            for (int c = 0; c < NUM_CS; c++) begin
                if (wr_kind == KIND_CSEL && wr_idx == IDX_W'(c)) begin
                    cfg_d.csel[c] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_o  = cfg_q.mask;
    assign win_o   = cfg_q.win;
    assign lbase_o = cfg_q.lbase;
    assign csel_o  = cfg_q.csel;

    // R8: a chip-select write is visible on the next cycle
    for (genvar c = 0; c < NUM_CS; c++) begin : g_wr_chk
        assert_csel_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_kind == KIND_CSEL && wr_idx == IDX_W'(c)) |=> (csel_o[c] == $past(wr_data)));
    end

    // R8: a mask write is visible on the next cycle
    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_mask_chk
        assert_mask_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_kind == KIND_MASK && wr_idx == IDX_W'(s)) |=> (mask_o[s] == $past(wr_data)));
    end

endmodule

// File: rtl/aw_space_match.sv
module aw_space_match
    import aw_pkg::*;
(
    input  addr_t bus_addr,
    input  logic  bus_is_io,
    input  addr_t mask_word,
    input  addr_t win_word,
    input  addr_t lbase_word,
    output logic  hit,
    output addr_t local_addr
);

    addr_t keep_hi;
    logic  enabled;
    logic  type_ok;
    logic  addr_ok;

    always_comb begin
        keep_hi    = mask_word & ~addr_t'(1);
        enabled    = lbase_word[0];
        type_ok    = (bus_is_io == mask_word[0]);
        addr_ok    = ((bus_addr & keep_hi) == (win_word & keep_hi));
        hit        = enabled & type_ok & addr_ok;
        local_addr = (bus_addr & ~keep_hi) | (lbase_word & keep_hi);
    end

endmodule

// File: rtl/aw_cs_match.sv
module aw_cs_match
    import aw_pkg::*;
(
    input  addr_t local_addr,
    input  addr_t cs_word,
    output logic  sel
);

    addr_t low;

    always_comb begin
        low = cs_low_mask(cs_word);
        sel = cs_word[0] & cs_has_size(cs_word)
            & ((local_addr & ~low) == (cs_word & ~low));
    end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import aw_pkg::*;
#(
    parameter  int unsigned NUM_SPACES = 5,
    parameter  int unsigned NUM_CS     = 4,
    localparam int unsigned IDX_MAX    = (NUM_SPACES > NUM_CS) ? NUM_SPACES : NUM_CS,
    localparam int unsigned IDX_W      = (IDX_MAX > 1) ? $clog2(IDX_MAX) : 1,
    localparam int unsigned HIT_W      = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
    localparam int unsigned SEL_W      = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              bus_valid,
    input  logic              bus_is_io,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output logic [HIT_W-1:0]  hit_space,
    output logic [ADDR_W-1:0] local_addr,
    output logic [NUM_CS-1:0] chip_sel
);

    typedef struct packed {
        logic              hit;
        logic [HIT_W-1:0]  idx;
        addr_t             laddr;
        logic [NUM_CS-1:0] cs;
    } result_t;

    logic [NUM_SPACES-1:0][ADDR_W-1:0] mask_v;
    logic [NUM_SPACES-1:0][ADDR_W-1:0] win_v;
    logic [NUM_SPACES-1:0][ADDR_W-1:0] lbase_v;
    logic [NUM_CS-1:0][ADDR_W-1:0]     csel_v;

    logic [NUM_SPACES-1:0]             space_hit;
    logic [NUM_SPACES-1:0][ADDR_W-1:0] space_la;

    logic              sel_found;
    logic [HIT_W-1:0]  sel_idx;
    addr_t             sel_la;
    logic [NUM_CS-1:0] cs_raw;

    result_t res_d, res_q;

    aw_cfg_regs #(
        .NUM_SPACES (NUM_SPACES),
        .NUM_CS     (NUM_CS),
        .IDX_W      (IDX_W)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_kind (reg_kind_e'(cfg_wr_sel[SEL_W-1 -: 2])),
        .wr_idx  (cfg_wr_sel[IDX_W-1:0]),
        .wr_data (cfg_wr_data),
        .mask_o  (mask_v),
        .win_o   (win_v),
        .lbase_o (lbase_v),
        .csel_o  (csel_v)
    );

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
        aw_space_match i_match (
            .bus_addr   (bus_addr),
            .bus_is_io  (bus_is_io),
            .mask_word  (mask_v[s]),
            .win_word   (win_v[s]),
            .lbase_word (lbase_v[s]),
            .hit        (space_hit[s]),
            .local_addr (space_la[s])
        );
    end

    // Fixed priority: the lowest index that matches wins.
    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        sel_la    = '0;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (!sel_found && bus_valid && space_hit[i]) begin
                sel_found = 1'b1;
                sel_idx   = HIT_W'(i);
                sel_la    = space_la[i];
            end
        end
    end

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        aw_cs_match i_cs (
            .local_addr (sel_la),
            .cs_word    (csel_v[c]),
            .sel        (cs_raw[c])
        );
    end

    always_comb begin
        res_d       = '0;
        res_d.hit   = sel_found;
        res_d.idx   = sel_idx;
        res_d.laddr = sel_la;
        res_d.cs    = sel_found ? cs_raw : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit        = res_q.hit;
    assign hit_space  = res_q.idx;
    assign local_addr = res_q.laddr;
    assign chip_sel   = res_q.cs;

    function automatic addr_t pick_word(input logic [NUM_SPACES-1:0][ADDR_W-1:0] v,
                                        input logic [HIT_W-1:0] k);
        addr_t r;
        r = '0;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (k == HIT_W'(i)) r = v[i];
        end
        return r;
    endfunction

    assert_valid_gates_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(bus_valid));

    assert_cs_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel != '0) |-> hit);

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((($past(space_hit) >> hit_space) & NUM_SPACES'(1)) != '0)
              && (($past(space_hit) & ((NUM_SPACES'(1) << hit_space) - NUM_SPACES'(1))) == '0)));

    assert_type_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((pick_word($past(mask_v), hit_space) & addr_t'(1)) == addr_t'($past(bus_is_io))));

    assert_enabled_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((pick_word($past(lbase_v), hit_space) & addr_t'(1)) != '0));

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((local_addr ^ $past(bus_addr))
                  & ~(pick_word($past(mask_v), hit_space) & ~addr_t'(1))) == '0));

endmodule

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [4:0]  cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic        bus_valid;
    logic        bus_is_io;
    logic [31:0] bus_addr;
    logic        hit;
    logic [2:0]  hit_space;
    logic [31:0] local_addr;
    logic [3:0]  chip_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    bit [31:0] m_mask [5];
    bit [31:0] m_win  [5];
    bit [31:0] m_lb   [5];
    bit [31:0] m_cs   [4];
    bit        e_hit;
    int        e_idx;
    bit [31:0] e_la;
    bit [3:0]  e_cs;

    always #10 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .bus_valid   (bus_valid),
        .bus_is_io   (bus_is_io),
        .bus_addr    (bus_addr),
        .hit         (hit),
        .hit_space   (hit_space),
        .local_addr  (local_addr),
        .chip_sel    (chip_sel)
    );

    task automatic model_eval();
        e_hit = 1'b0; e_idx = 0; e_la = '0; e_cs = '0;
        if (!rst_n) begin
            foreach (m_mask[s]) begin m_mask[s] = '0; m_win[s] = '0; m_lb[s] = '0; end
            foreach (m_cs[c]) m_cs[c] = '0;
            return;
        end
        if (bus_valid) begin
            for (int s = 0; s < 5; s++) begin
                bit [31:0] m;
                m = m_mask[s] & 32'hFFFF_FFFE;
                if (!e_hit && m_lb[s][0] && (m_mask[s][0] == bus_is_io)
                    && ((bus_addr & m) == (m_win[s] & m))) begin
                    e_hit = 1'b1;
                    e_idx = s;
                    e_la  = (bus_addr & ~m) | (m_lb[s] & m);
                end
            end
        end
        if (e_hit) begin
            for (int c = 0; c < 4; c++) begin
                int k;
                k = -1;
                for (int b = 1; b < 32; b++) if (k < 0 && m_cs[c][b]) k = b;
                if (m_cs[c][0] && k >= 0) begin
                    bit [32:0] size;
                    bit [31:0] low;
                    size = 33'd1 << (k + 1);
                    low  = 32'(size - 33'd1);
                    if ((e_la & ~low) == (m_cs[c] & ~low)) e_cs[c] = 1'b1;
                end
            end
        end
        if (cfg_wr_en) begin
            int idx;
            idx = int'(cfg_wr_sel[2:0]);
            case (cfg_wr_sel[4:3])
                2'd0: if (idx < 5) m_mask[idx] = cfg_wr_data;
                2'd1: if (idx < 5) m_win[idx]  = cfg_wr_data;
                2'd2: if (idx < 5) m_lb[idx]   = cfg_wr_data;
                default: if (idx < 4) m_cs[idx] = cfg_wr_data;
            endcase
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_eval();
        @(negedge clk);
        checks++;
        if (hit !== e_hit || hit_space !== 3'(e_idx) || local_addr !== e_la || chip_sel !== e_cs) begin
            fails++;
            $display("FAIL %s: hit=%0b/%0b space=%0d/%0d local=%h/%h cs=%b/%b (actual/expected)",
                     tag, hit, e_hit, hit_space, e_idx, local_addr, e_la, chip_sel, e_cs);
        end
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr(input bit [1:0] kind, input int idx, input bit [31:0] data);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = {kind, 3'(idx)};
        cfg_wr_data = data;
        tick("R8");
    endtask

    task automatic acc(input bit io, input bit [31:0] a, input string tag);
        bus_valid = 1'b1;
        bus_is_io = io;
        bus_addr  = a;
        tick(tag);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_data = '0;
        bus_valid = 1'b1; bus_is_io = 1'b0; bus_addr = 32'hFFCF_0014;
        repeat (3) tick("R1");
        @(negedge clk);
        rst_n = 1'b1;
        acc(1'b0, 32'h0000_0000, "R1");
        acc(1'b1, 32'h0000_0000, "R1");

        // space 0: 1 KB memory window at 0xFFCF0000 -> local 0x1000
        wr(2'd0, 0, 32'hFFFF_FC00);
        wr(2'd1, 0, 32'hFFCF_0000);
        acc(1'b0, 32'hFFCF_0014, "R3");
        wr(2'd2, 0, 32'h0000_1001);
        acc(1'b0, 32'hFFCF_0014, "R4");
        acc(1'b0, 32'hFFCF_03FC, "R5");
        acc(1'b0, 32'hFFCF_0400, "R4");
        acc(1'b1, 32'hFFCF_0014, "R2");

        // chip selects: cs0 0x1201 -> 0x1000..0x13FF, cs3 0x1081 -> 0x1000..0x10FF
        wr(2'd3, 0, 32'h0000_1201);
        wr(2'd3, 3, 32'h0000_1081);
        wr(2'd3, 2, 32'h0000_0001);
        acc(1'b0, 32'hFFCF_0014, "R9");
        acc(1'b0, 32'hFFCF_0200, "R9");
        acc(1'b0, 32'hFFCF_0000, "R10");

        // space 1: 32-byte I/O window at 0xFC00 -> local 0x300, cs1 0x311
        wr(2'd0, 1, 32'hFFFF_FFE1);
        wr(2'd1, 1, 32'h0000_FC00);
        wr(2'd2, 1, 32'h0000_0301);
        wr(2'd3, 1, 32'h0000_0311);
        acc(1'b1, 32'h0000_FC08, "R5");
        acc(1'b0, 32'h0000_FC08, "R2");
        acc(1'b1, 32'h0000_FC1F, "R9");
        acc(1'b1, 32'h0000_FC20, "R4");

        // space 2 overlaps space 0: 64 KB window -> local 0x20000
        wr(2'd0, 2, 32'hFFFF_0000);
        wr(2'd1, 2, 32'hFFCF_0000);
        wr(2'd2, 2, 32'h0002_0001);
        acc(1'b0, 32'hFFCF_0014, "R6");
        acc(1'b0, 32'hFFCF_8000, "R6");

        // space 3 programmed but disabled
        wr(2'd0, 3, 32'hFFFF_F000);
        wr(2'd1, 3, 32'h8000_0000);
        wr(2'd2, 3, 32'h0000_7000);
        acc(1'b0, 32'h8000_0010, "R3");

        // space 4: enable written in the same cycle as an access
        wr(2'd0, 4, 32'hFFFF_F000);
        wr(2'd1, 4, 32'h4000_0000);
        bus_valid = 1'b1; bus_is_io = 1'b0; bus_addr = 32'h4000_0010;
        cfg_wr_en = 1'b1; cfg_wr_sel = {2'd2, 3'd4}; cfg_wr_data = 32'h0000_5001;
        tick("R8");
        acc(1'b0, 32'h4000_0010, "R8");

        // idle cycle
        bus_valid = 1'b0;
        tick("R7");
        acc(1'b0, 32'hFFCF_0014, "R7");

        // mixed sweep with random chip-select and local-base rewrites
        for (int n = 0; n < 400; n++) begin
            bit [31:0] bases [4];
            bases[0] = 32'hFFCF_0000; bases[1] = 32'h0000_FC00;
            bases[2] = 32'h8000_0000; bases[3] = 32'h4000_0000;
            bus_valid = ($urandom_range(0, 7) != 0);
            bus_is_io = ($urandom_range(0, 3) == 0);
            bus_addr  = bases[$urandom_range(0, 3)] + 32'($urandom_range(0, 32'h1_FFFF));
            if ($urandom_range(0, 9) == 0) begin
                cfg_wr_en   = 1'b1;
                cfg_wr_sel  = {2'd3, 3'($urandom_range(0, 3))};
                cfg_wr_data = (32'h0000_1000 + 32'($urandom_range(0, 32'h3FF))) | 32'($urandom_range(0, 1));
            end else if ($urandom_range(0, 14) == 0) begin
                cfg_wr_en   = 1'b1;
                cfg_wr_sel  = {2'd2, 3'($urandom_range(0, 4))};
                cfg_wr_data = {16'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 11'h000, 1'($urandom_range(0, 1))};
            end
            tick(bus_is_io ? "R2" : "R6");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule